// File: doc/BRIEF.md
# Associative Translation Cache with Pinned Entries

This block is a small fully associative cache that turns virtual page numbers into physical frame numbers. Any stored entry can hold any page. A lookup is answered in the same cycle from the stored tags. On a hit the block returns the frame. On a miss it asks an external page-table walker for the translation and waits for the walker's answer. A good answer is written into the cache. An answer that marks the page illegal raises a one-cycle fault and changes nothing in the cache.

Entries can be pinned when they are installed. A pinned entry is never picked as a victim and survives a bulk flush. It leaves the cache only through the single-entry invalidate port. Victims are chosen in this order: the lowest-numbered empty slot first. If there is none, a rotating pointer picks the next entry that is not pinned. If every slot is full and pinned, the fill is discarded and a sticky overflow flag is raised. Two saturating counters record lookup hits and misses so that the hit ratio can be measured, and a synchronous clear zeroes both.

Top module: `tlb_cache`

## Requirements
- R1: When `lk_valid` is high and `lk_vpn` matches a valid entry, `lk_hit` is 1 and `lk_pfn` is that entry's frame in the same cycle. Otherwise `lk_hit` is 0 and `lk_pfn` is 0. `lk_miss` is `lk_valid` with no match.
- R2: A miss while no walk is outstanding raises `walk_req` at the next clock edge, with `walk_vpn` equal to the missed page. `walk_req` stays high until the edge at which `rsp_valid` is sampled, and it is low after that edge. Only one walk is outstanding at a time.
- R3: A response with `rsp_ok`=1 installs the pair (`walk_vpn`, `rsp_pfn`) and its pin bit `rsp_wired`. The entry goes into the lowest-index empty slot whenever an empty slot exists.
- R4: When no slot is empty, the victim is the first unpinned entry found scanning upward (with wrap) from a rotating pointer. The pointer is 0 after reset and moves to the slot after each evicted one.
- R5: A pinned entry is never evicted. If all slots are valid and pinned, the fill is dropped and `overflow` becomes 1 and stays 1 until reset.
- R6: A response with `rsp_ok`=0 installs nothing and drives `fault` high for exactly the one cycle after the response edge.
- R7: `flush` invalidates every unpinned entry at one edge. Pinned entries keep translating.
- R8: `inv_valid` with index `inv_idx` clears that one slot, pinned or not, at the next edge.
- R9: `hit_cnt` counts cycles with `lk_hit`=1 and `miss_cnt` counts cycles with `lk_miss`=1. Each is CNT_W bits wide and holds at all-ones once it gets there.
- R10: `cnt_clr` zeroes both counters at the next edge and takes priority over a count in that same cycle.
- R11: After reset the cache is empty. `walk_req`, `fault`, `overflow` and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Page number to translate |
| lk_hit | output | 1 | Lookup matched |
| lk_miss | output | 1 | Lookup did not match |
| lk_pfn | output | PFN_W | Frame on a hit, 0 otherwise |
| walk_req | output | 1 | Walk outstanding |
| walk_vpn | output | VPN_W | Page being walked |
| rsp_valid | input | 1 | Walker answer present |
| rsp_ok | input | 1 | Answer marks page legal |
| rsp_pfn | input | PFN_W | Frame from walker |
| rsp_wired | input | 1 | Pin the installed entry |
| flush | input | 1 | Invalidate all unpinned entries |
| inv_valid | input | 1 | Invalidate one slot |
| inv_idx | input | IW | Slot to invalidate |
| cnt_clr | input | 1 | Clear both counters |
| hit_cnt | output | CNT_W | Saturating hit count |
| miss_cnt | output | CNT_W | Saturating miss count |
| fault | output | 1 | One-cycle illegal-page pulse |
| overflow | output | 1 | Sticky: a fill found only pinned slots |

## Verification
The bench fills the cache past capacity while slot 0 is pinned. A victim picker that ignored pins would evict that slot, and the pinned page would then miss. A pointer that failed to advance would evict the same slot twice, so a later lookup of the second victim would still hit. A flush that ignored pins, or an invalidate that respected them, shows up as a pinned page that hits or misses wrongly afterward. Filling four pinned slots and then a fifth page checks that the fill is dropped rather than overwriting a pinned slot. Illegal-page answers must give a single fault cycle and no installation. Driving far more hits than the counter can hold exposes counters that wrap instead of saturating.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [1:0] {
        FILL_FREE  = 2'd0,
        FILL_EVICT = 2'd1,
        FILL_DROP  = 2'd2
    } fill_kind_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int N     = 8,
    parameter int VPN_W = 20,
    localparam int IW   = $clog2(N)
) (
    input  logic [N-1:0]            vld,
    input  logic [N-1:0][VPN_W-1:0] tags,
    input  logic [VPN_W-1:0]        key,
    output logic                    hit,
    output logic [IW-1:0]           idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (!hit && vld[i] && tags[i] == key) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
#(
    parameter int N   = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vld,
    input  logic [N-1:0]  wired,
    input  logic [IW-1:0] rr,
    output fill_kind_e    kind,
    output logic [IW-1:0] slot
);
    always_comb begin
        logic found;
        int   j;
        found = 1'b0;
        kind  = FILL_DROP;
        slot  = '0;
        for (int i = 0; i < N; i++) begin
            if (!found && !vld[i]) begin
                found = 1'b1;
                kind  = FILL_FREE;
                slot  = IW'(i);
            end
        end
        for (int k = 0; k < N; k++) begin
            j = int'(rr) + k;
            if (j >= N) j = j - N;
            if (!found && !wired[j]) begin
                found = 1'b1;
                kind  = FILL_EVICT;
                slot  = IW'(j);
            end
        end
    end
endmodule

// File: rtl/tlb_sat_cnt.sv
module tlb_sat_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                    cnt_d = '0;
        else if (inc && ~&cnt_q)    cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R9
    cnt_sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&cnt_q && !clr) |=> &cnt_q);
    // R10
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0);
endmodule

// File: rtl/tlb_cache.sv
module tlb_cache
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int CNT_W   = 32,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic [PFN_W-1:0] lk_pfn,
    output logic             walk_req,
    output logic [VPN_W-1:0] walk_vpn,
    input  logic             rsp_valid,
    input  logic             rsp_ok,
    input  logic [PFN_W-1:0] rsp_pfn,
    input  logic             rsp_wired,
    input  logic             flush,
    input  logic             inv_valid,
    input  logic [IW-1:0]    inv_idx,
    input  logic             cnt_clr,
    output logic [CNT_W-1:0] hit_cnt,
    output logic [CNT_W-1:0] miss_cnt,
    output logic             fault,
    output logic             overflow
);
    typedef struct packed {
        logic [ENTRIES-1:0]            vld;
        logic [ENTRIES-1:0]            wired;
        logic [ENTRIES-1:0][VPN_W-1:0] vpn;
        logic [ENTRIES-1:0][PFN_W-1:0] pfn;
        logic [IW-1:0]                 rr;
        logic                          pend;
        logic [VPN_W-1:0]              wvpn;
        logic                          fault;
        logic                          ovf;
    } state_t;

    state_t     st_d, st_q;
    logic       m_hit;
    logic [IW-1:0] m_idx;
    fill_kind_e v_kind;
    logic [IW-1:0] v_slot;
    logic       fill_go;

    tlb_match #(.N(ENTRIES), .VPN_W(VPN_W)) u_match (
        .vld (st_q.vld),
        .tags(st_q.vpn),
        .key (lk_vpn),
        .hit (m_hit),
        .idx (m_idx)
    );

    tlb_victim #(.N(ENTRIES)) u_victim (
        .vld  (st_q.vld),
        .wired(st_q.wired),
        .rr   (st_q.rr),
        .kind (v_kind),
        .slot (v_slot)
    );

    assign lk_hit  = lk_valid && m_hit;
    assign lk_miss = lk_valid && !m_hit;
    assign lk_pfn  = lk_hit ? st_q.pfn[m_idx] : '0;
    assign fill_go = rsp_valid && st_q.pend && rsp_ok;

    always_comb begin
        st_d       = st_q;
        st_d.fault = 1'b0;
        if (flush) st_d.vld = st_q.vld & st_q.wired;
        if (inv_valid) begin
            st_d.vld[inv_idx]   = 1'b0;
            st_d.wired[inv_idx] = 1'b0;
        end
        if (rsp_valid && st_q.pend) begin
            st_d.pend = 1'b0;
            if (!rsp_ok) begin
                st_d.fault = 1'b1;
            end else if (v_kind == FILL_DROP) begin
                st_d.ovf = 1'b1;
            end else begin
                st_d.vld[v_slot]   = 1'b1;
                st_d.wired[v_slot] = rsp_wired;
                st_d.vpn[v_slot]   = st_q.wvpn;
                st_d.pfn[v_slot]   = rsp_pfn;
                if (v_kind == FILL_EVICT)
                    st_d.rr = (int'(v_slot) == ENTRIES - 1) ? '0 : v_slot + 1'b1;
            end
        end
        if (lk_miss && !st_q.pend) begin
            st_d.pend = 1'b1;
            st_d.wvpn = lk_vpn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign walk_req = st_q.pend;
    assign walk_vpn = st_q.wvpn;
    assign fault    = st_q.fault;
    assign overflow = st_q.ovf;

    tlb_sat_cnt #(.W(CNT_W)) u_hits (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(lk_hit), .cnt(hit_cnt)
    );
    tlb_sat_cnt #(.W(CNT_W)) u_misses (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(lk_miss), .cnt(miss_cnt)
    );

    // R1
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss));
    // R2
    walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !rsp_valid) |=> (walk_req && $stable(walk_vpn)));
    // R5
    victim_unpinned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_go && v_kind == FILL_EVICT) |-> !st_q.wired[v_slot]);
    // R5
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    // R6
    fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_pin
            // R5
            pinned_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.vld[g] && st_q.wired[g] && !(inv_valid && int'(inv_idx) == g))
                |=> (st_q.vld[g] && $stable(st_q.vpn[g])));
        end
    endgenerate
endmodule

// File: tb/sim_tlb_cache.sv
module sim_tlb_cache;
    localparam int N = 4, VW = 12, PW = 12, CW = 6, IW = 2;
    localparam logic [2:0] OP_LOOK = 3'd0, OP_FILL = 3'd1, OP_FLUSH = 3'd2, OP_INV = 3'd3;

    typedef struct packed {
        logic [2:0]    op;
        logic [VW-1:0] vpn;
        logic [PW-1:0] pfn;
        logic          wired;
        logic [IW-1:0] idx;
        logic          exp_hit;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t TBL [NV] = '{
        '{OP_FILL,  12'h0A1, 12'h101, 1'b1, 2'd0, 1'b0},
        '{OP_FILL,  12'h0B2, 12'h202, 1'b0, 2'd0, 1'b0},
        '{OP_FILL,  12'h0C3, 12'h303, 1'b0, 2'd0, 1'b0},
        '{OP_FILL,  12'h0D4, 12'h404, 1'b0, 2'd0, 1'b0},
        '{OP_LOOK,  12'h0A1, 12'h101, 1'b0, 2'd0, 1'b1},
        '{OP_LOOK,  12'h0D4, 12'h404, 1'b0, 2'd0, 1'b1},
        '{OP_FILL,  12'h0E5, 12'h505, 1'b0, 2'd0, 1'b0},
        '{OP_LOOK,  12'h0B2, 12'h000, 1'b0, 2'd0, 1'b0},
        '{OP_LOOK,  12'h0E5, 12'h505, 1'b0, 2'd0, 1'b1},
        '{OP_LOOK,  12'h0A1, 12'h101, 1'b0, 2'd0, 1'b1},
        '{OP_FILL,  12'h0F6, 12'h606, 1'b0, 2'd0, 1'b0},
        '{OP_LOOK,  12'h0C3, 12'h000, 1'b0, 2'd0, 1'b0},
        '{OP_LOOK,  12'h0F6, 12'h606, 1'b0, 2'd0, 1'b1},
        '{OP_FLUSH, 12'h000, 12'h000, 1'b0, 2'd0, 1'b0},
        '{OP_LOOK,  12'h0F6, 12'h000, 1'b0, 2'd0, 1'b0},
        '{OP_LOOK,  12'h0A1, 12'h101, 1'b0, 2'd0, 1'b1},
        '{OP_INV,   12'h000, 12'h000, 1'b0, 2'd0, 1'b0},
        '{OP_LOOK,  12'h0A1, 12'h000, 1'b0, 2'd0, 1'b0},
        '{OP_FILL,  12'h100, 12'h0AA, 1'b1, 2'd0, 1'b0},
        '{OP_FILL,  12'h101, 12'h0AB, 1'b1, 2'd0, 1'b0},
        '{OP_FILL,  12'h102, 12'h0AC, 1'b1, 2'd0, 1'b0},
        '{OP_FILL,  12'h103, 12'h0AD, 1'b1, 2'd0, 1'b0},
        '{OP_FILL,  12'h1FF, 12'h0FF, 1'b0, 2'd0, 1'b0},
        '{OP_LOOK,  12'h1FF, 12'h000, 1'b0, 2'd0, 1'b0},
        '{OP_LOOK,  12'h103, 12'h0AD, 1'b0, 2'd0, 1'b1},
        '{OP_INV,   12'h000, 12'h000, 1'b0, 2'd1, 1'b0},
        '{OP_LOOK,  12'h101, 12'h000, 1'b0, 2'd0, 1'b0},
        '{OP_FILL,  12'h222, 12'h333, 1'b0, 2'd0, 1'b0},
        '{OP_LOOK,  12'h222, 12'h333, 1'b0, 2'd0, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic lk_valid = 1'b0, rsp_valid = 1'b0, rsp_ok = 1'b0, rsp_wired = 1'b0;
    logic flush = 1'b0, inv_valid = 1'b0, cnt_clr = 1'b0;
    logic [VW-1:0] lk_vpn = '0;
    logic [PW-1:0] rsp_pfn = '0;
    logic [IW-1:0] inv_idx = '0;
    logic lk_hit, lk_miss, walk_req, fault, overflow;
    logic [PW-1:0] lk_pfn;
    logic [VW-1:0] walk_vpn;
    logic [CW-1:0] hit_cnt, miss_cnt;

    int checks = 0, fails = 0, exp_hits = 0, exp_miss = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tlb_cache #(.ENTRIES(N), .VPN_W(VW), .PFN_W(PW), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pfn(lk_pfn),
        .walk_req(walk_req), .walk_vpn(walk_vpn),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_pfn(rsp_pfn), .rsp_wired(rsp_wired),
        .flush(flush), .inv_valid(inv_valid), .inv_idx(inv_idx), .cnt_clr(cnt_clr),
        .hit_cnt(hit_cnt), .miss_cnt(miss_cnt), .fault(fault), .overflow(overflow)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // walk answer for the outstanding request
    task automatic answer(input logic ok, input logic [PW-1:0] pfn, input logic w);
        rsp_valid = 1'b1; rsp_ok = ok; rsp_pfn = pfn; rsp_wired = w;
        tick();
        rsp_valid = 1'b0; rsp_ok = 1'b0;
        chk("R2 walk_req low after answer", walk_req, 0);
    endtask

    task automatic do_look(input vec_t v);
        lk_valid = 1'b1; lk_vpn = v.vpn;
        #1;
        chk("R1 hit", lk_hit, v.exp_hit);
        chk("R1 pfn", lk_pfn, v.exp_hit ? v.pfn : '0);
        if (v.exp_hit) exp_hits++; else exp_miss++;
        @(posedge clk); @(negedge clk);
        lk_valid = 1'b0;
        if (!v.exp_hit) begin
            chk("R2 walk_req", walk_req, 1);
            chk("R2 walk_vpn", walk_vpn, v.vpn);
            answer(1'b0, '0, 1'b0);
            chk("R6 fault pulse", fault, 1);
            tick();
            chk("R6 fault one cycle", fault, 0);
        end
    endtask

    task automatic do_fill(input vec_t v);
        lk_valid = 1'b1; lk_vpn = v.vpn;
        #1;
        chk("R3 fill lookup misses", lk_miss, 1);
        exp_miss++;
        @(posedge clk); @(negedge clk);
        lk_valid = 1'b0;
        chk("R2 walk_vpn", walk_vpn, v.vpn);
        answer(1'b1, v.pfn, v.wired);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 walk_req", walk_req, 0);
        chk("R11 fault", fault, 0);
        chk("R11 overflow", overflow, 0);
        chk("R11 hit_cnt", hit_cnt, 0);
        rst_n = 1'b1;
        tick();
        lk_valid = 1'b1; lk_vpn = 12'h0A1; #1;
        chk("R11 empty after reset", lk_hit, 0);
        lk_valid = 1'b0;
        chk("R11 miss_cnt", miss_cnt, 0);

        // R3 R4 R5 R7 R8 covered by table order
        for (int i = 0; i < NV; i++) begin
            case (TBL[i].op)
                OP_LOOK: do_look(TBL[i]);
                OP_FILL: do_fill(TBL[i]);
                OP_FLUSH: begin flush = 1'b1; tick(); flush = 1'b0; end
                default: begin
                    inv_valid = 1'b1; inv_idx = TBL[i].idx; tick(); inv_valid = 1'b0;
                end
            endcase
            if (i == 21) chk("R5 no overflow yet", overflow, 0);
            if (i == 22) chk("R5 overflow on all pinned", overflow, 1);
        end
        chk("R5 overflow sticky", overflow, 1);
        chk("R9 hit count", hit_cnt, exp_hits);
        chk("R9 miss count", miss_cnt, exp_miss);

        // R10 clear wins over a hit in the same cycle
        lk_valid = 1'b1; lk_vpn = 12'h100; cnt_clr = 1'b1;
        tick();
        cnt_clr = 1'b0; lk_valid = 1'b0;
        chk("R10 hit clear priority", hit_cnt, 0);
        chk("R10 miss clear", miss_cnt, 0);

        // R9 saturation
        lk_valid = 1'b1; lk_vpn = 12'h100;
        for (int k = 0; k < 70; k++) tick();
        lk_valid = 1'b0;
        chk("R9 hit saturates", hit_cnt, 63);
        chk("R9 miss unchanged", miss_cnt, 0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule